// File: doc/BRIEF.md
# Per-Bank Access Gap Timer

This block enforces a minimum idle time between two memory patterns that one memory machine runs against the same bank. When the pattern sequencer reaches a pattern word that carries the gap flag, it pulses an arm input and names the bank being accessed. That bank's countdown is then loaded from a 2-bit period code. Until the countdown reaches zero, any request for that bank is refused.

Each bank has its own timer. A request for a bank whose timer is idle is granted at once, even while another bank is still counting down. The result is a combinational allow signal, so the requester learns in the same cycle whether its pattern may start. The block does not execute patterns and does not arbitrate between machines.

Top module: `bank_gap_timer`

## Requirements
- R1: The period code c (2 bits) selects a gap of c+1 cycles. 2'b00 gives 1 cycle, 2'b01 gives 2, 2'b10 gives 3 and 2'b11 gives 4. After the clock edge that samples an arm for a bank, a request to that bank is refused in the c+1 cycles that follow and is allowed again in the next cycle.
- R2: allow_o is high exactly when req_i is high and the timer of the bank on req_bank_i is at zero. The output follows the inputs in the same cycle with no register on the path. With req_i low, allow_o is low.
- R3: While the timer of a bank is running, a request to that bank gives allow_o low.
- R4: A request to a bank whose own timer is idle is allowed even when other banks' timers are running, including in the cycle right after another bank was armed.
- R5: After reset every bank timer is zero, so a request to any bank is allowed. This also holds when reset arrives during a running countdown.
- R6: An arm for a bank whose timer is still running reloads that timer with the full period of the current code. The count does not continue from its old value.
- R7: The period code is taken only at the arm edge. A change of code while a countdown runs does not change that countdown.
- R8: An arm takes effect at the clock edge. In the cycle where arm_i is high, allow_o for the armed bank still reflects the timer value held before the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_code_i | input | 2 | Gap length code, sampled on arm |
| arm_i | input | 1 | One-cycle start pulse from the pattern sequencer |
| arm_bank_i | input | 3 | Bank whose timer the arm starts |
| req_i | input | 1 | A new pattern is requested |
| req_bank_i | input | 3 | Bank the request targets |
| allow_o | output | 1 | Request may start now |

## Verification
allow_o is combinational. Every expected value therefore belongs to the same cycle in which the request is driven. An arm moves a timer only at the following rising edge, so a gap of c+1 cycles shows as c+1 refused cycles that start one cycle after the arm. The bench drives inputs on the falling edge and samples allow_o 2 ns later, well before the next rising edge. Its vector table advances exactly one cycle per entry, so each expected value is placed in the cycle counted from the arm edge. Where several banks are probed within one cycle, the probes are spaced inside the low phase of the clock.

// File: rtl/bank_gap_pkg.sv
package bank_gap_pkg;
    localparam int CODE_W     = 2;
    localparam int MAX_PERIOD = 1 << CODE_W;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    typedef logic [CNT_W-1:0] gap_cnt_t;

    typedef struct packed {
        gap_cnt_t cnt;
    } gap_state_t;
endpackage

// File: rtl/gap_period_dec.sv
module gap_period_dec
    import bank_gap_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output gap_cnt_t          load_val_o
);
    // code c maps to a gap of c+1 cycles
    always_comb begin
        load_val_o = gap_cnt_t'(code_i) + gap_cnt_t'(1);
    end
endmodule

// File: rtl/gap_bank_counter.sv
module gap_bank_counter
    import bank_gap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  gap_cnt_t load_val_i,
    output logic     busy_o
);
    gap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - gap_cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != '0);
endmodule

// File: rtl/gap_allow_sel.sv
module gap_allow_sel #(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] busy_i,
    input  logic                 req_i,
    input  logic [BANK_W-1:0]    req_bank_i,
    output logic                 allow_o
);
    always_comb begin
        allow_o = req_i && !busy_i[req_bank_i];
    end
endmodule

// File: rtl/bank_gap_timer.sv
module bank_gap_timer
    import bank_gap_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] period_code_i,
    input  logic              arm_i,
    input  logic [BANK_W-1:0] arm_bank_i,
    input  logic              req_i,
    input  logic [BANK_W-1:0] req_bank_i,
    output logic              allow_o
);
    gap_cnt_t             load_val;
    logic [NUM_BANKS-1:0] bank_busy;

    gap_period_dec u_dec (
        .code_i     (period_code_i),
        .load_val_o (load_val)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic load_b;
        assign load_b = arm_i && (arm_bank_i == BANK_W'(b));
        gap_bank_counter u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load_b),
            .load_val_i (load_val),
            .busy_o     (bank_busy[b])
        );
    end

    gap_allow_sel #(.NUM_BANKS(NUM_BANKS)) u_sel (
        .busy_i     (bank_busy),
        .req_i      (req_i),
        .req_bank_i (req_bank_i),
        .allow_o    (allow_o)
    );
endmodule

// File: rtl/bank_gap_timer_chk.sv
module bank_gap_timer_chk
    import bank_gap_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CODE_W-1:0]    period_code_i,
    input logic                 arm_i,
    input logic [BANK_W-1:0]    arm_bank_i,
    input logic                 req_i,
    input logic [BANK_W-1:0]    req_bank_i,
    input logic                 allow_o,
    input logic [NUM_BANKS-1:0] bank_busy
);
    a_r3_armed_bank_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> bank_busy[$past(arm_bank_i)]);

    a_r2_no_req_no_allow: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |-> !allow_o);

    a_r2_free_bank_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !bank_busy[req_bank_i]) |-> allow_o);

    a_r5_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_busy == '0));

    a_r1_single_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && period_code_i == '0) ##1 !arm_i |=> !bank_busy[$past(arm_bank_i, 2)]);
endmodule

bind bank_gap_timer bank_gap_timer_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_code_i (period_code_i),
    .arm_i         (arm_i),
    .arm_bank_i    (arm_bank_i),
    .req_i         (req_i),
    .req_bank_i    (req_bank_i),
    .allow_o       (allow_o),
    .bank_busy     (bank_busy)
);

// File: tb/bank_gap_timer_tb_top.sv
`timescale 1ns/100ps
module bank_gap_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] period_code_i = '0;
    logic       arm_i = 1'b0;
    logic [2:0] arm_bank_i = '0;
    logic       req_i = 1'b0;
    logic [2:0] req_bank_i = '0;
    logic       allow_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    bank_gap_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_code_i (period_code_i),
        .arm_i         (arm_i),
        .arm_bank_i    (arm_bank_i),
        .req_i         (req_i),
        .req_bank_i    (req_bank_i),
        .allow_o       (allow_o)
    );

    // fields: {rid[3:0], arm, arm_bank[2:0], code[1:0], req, req_bank[2:0], expected allow}
    localparam int NV = 22;
    localparam logic [14:0] VEC [NV] = '{
        {4'd5, 1'b0, 3'd0, 2'd0, 1'b1, 3'd3, 1'b1}, // R5 fresh from reset
        {4'd8, 1'b1, 3'd2, 2'd1, 1'b1, 3'd2, 1'b1}, // R8 arm cycle sees old state
        {4'd3, 1'b0, 3'd0, 2'd1, 1'b1, 3'd2, 1'b0}, // R3 bank 2 running
        {4'd1, 1'b0, 3'd0, 2'd1, 1'b1, 3'd2, 1'b0}, // R1 second gap cycle
        {4'd1, 1'b0, 3'd0, 2'd1, 1'b1, 3'd2, 1'b1}, // R1 gap over
        {4'd8, 1'b1, 3'd4, 2'd3, 1'b1, 3'd4, 1'b1}, // R8 arm bank 4, 4 cycles
        {4'd4, 1'b0, 3'd0, 2'd3, 1'b1, 3'd1, 1'b1}, // R4 other bank right away
        {4'd3, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b0}, // R3
        {4'd6, 1'b1, 3'd4, 2'd3, 1'b1, 3'd6, 1'b1}, // R6 re-arm running bank 4
        {4'd6, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b0}, // R6
        {4'd6, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b0}, // R6 old count would be free
        {4'd6, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b0}, // R6
        {4'd6, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b0}, // R6
        {4'd6, 1'b0, 3'd0, 2'd3, 1'b1, 3'd4, 1'b1}, // R6 full reload expired
        {4'd2, 1'b1, 3'd0, 2'd2, 1'b0, 3'd0, 1'b0}, // R2 no request, no allow
        {4'd7, 1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 1'b0}, // R7 code changed to 00
        {4'd7, 1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 1'b0}, // R7
        {4'd7, 1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 1'b0}, // R7 three cycles kept
        {4'd7, 1'b0, 3'd0, 2'd0, 1'b1, 3'd0, 1'b1}, // R7
        {4'd1, 1'b1, 3'd7, 2'd0, 1'b1, 3'd7, 1'b1}, // R1 code 00 arm
        {4'd1, 1'b0, 3'd0, 2'd0, 1'b1, 3'd7, 1'b0}, // R1 one blocked cycle
        {4'd1, 1'b0, 3'd0, 2'd0, 1'b1, 3'd7, 1'b1}  // R1
    };

    task automatic check(input int rid, input logic exp);
        n_checks++;
        if (allow_o !== exp) begin
            n_fails++;
            $display("FAIL R%0d: allow_o=%b expected %b (t=%0t)", rid, allow_o, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        arm_i = 1'b0;
        req_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            arm_i         = VEC[i][10];
            arm_bank_i    = VEC[i][9:7];
            period_code_i = VEC[i][6:5];
            req_i         = VEC[i][4];
            req_bank_i    = VEC[i][3:1];
            #2;
            check(int'(VEC[i][14:11]), VEC[i][0]);
        end

        // R4: arm bank 6 for 4 cycles, then probe every other bank in one cycle
        @(negedge clk);
        idle_inputs();
        arm_i = 1'b1; arm_bank_i = 3'd6; period_code_i = 2'd3;
        @(negedge clk);
        arm_i = 1'b0; req_i = 1'b1;
        for (int b = 0; b < 8; b++) begin
            req_bank_i = 3'(b);
            #0.5;
            check(4, (b != 6));
        end

        // R5: reset during a running countdown clears it
        @(negedge clk);
        idle_inputs();
        arm_i = 1'b1; arm_bank_i = 3'd3; period_code_i = 2'd3;
        @(negedge clk);
        arm_i = 1'b0; req_i = 1'b1; req_bank_i = 3'd3;
        #2;
        check(3, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(5, 1'b1);

        // R2: no request on a free bank still gives no allow
        @(negedge clk);
        req_i = 1'b0; req_bank_i = 3'd5;
        #2;
        check(2, 1'b0);

        @(negedge clk);
        idle_inputs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule